// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Halt

This block sets the instruction-cycle rhythm of a small controller that fetches 16-bit instruction words from a program store of up to 8192 words. It divides every instruction cycle into four quarters. It keeps a program counter and an address register, and it drives the address register onto the program address bus. It also drives a master clock for peripherals, high in the last quarter of each cycle. Late in every cycle the next address is chosen: either the incremented program counter or a jump target that decode presents with a load strobe.

Two active-low controls stop the sequencer, and they stop it in different ways. Reset acts at once and asynchronously. It clears the address, stops the master clock and forces both bank-select outputs high. Halt is sampled only at the end of an instruction cycle. From the next cycle on, it freezes every internal register while the quarter phases and the master clock keep running. During halt both bank-select outputs are forced high from the first quarter of each halted cycle. When halt is released, the sequencer resumes at the held address. The bank-select outputs otherwise pass through the requests that decode makes for the left and right peripheral banks.

States: `ST_Q1`, `ST_Q2`, `ST_Q3` and `ST_Q4` are the four quarters of a running cycle, and `ST_HALT` is the frozen state. The transitions are:

- `ST_Q1`→`ST_Q2`→`ST_Q3`→`ST_Q4`, one quarter per clock.
- `ST_Q4`→`ST_Q1` when `halt_n` is high; this is the run transition.
- `ST_Q4`→`ST_HALT` when `halt_n` is low; this is the enter transition.
- `ST_HALT`→`ST_HALT` while halt is held or before the last quarter.
- `ST_HALT`→`ST_Q1` at the end of a halted cycle's last quarter when `halt_n` is high; this is the resume transition.

Reset drives every state to `ST_Q1` asynchronously.

Top module: `instr_cycle_seq`

## Requirements
- R1: `phase` is one-hot and steps through bit 0, 1, 2, 3 (first to fourth quarter), advancing one bit per `clk` rising edge. It keeps stepping while halted.
- R2: `mclk` is high exactly while `phase[3]` is high, both when running and when halted. It is held low while `rst_n` is low.
- R3: Without a jump, `addr` advances by one per instruction cycle. It changes only at the edge that ends the third quarter, and it wraps from 8191 to 0 with the default width of 13 bits.
- R4: When `jmp_ld` is high at the edge that ends the second quarter, `jmp_tgt` becomes the next cycle's address. A strobe that is present only in the first or the fourth quarter is ignored.
- R5: While `rst_n` is low, `addr` is 0, `mclk` is 0 and `lb_n`/`rb_n` are 1, taking effect without a clock edge. The first cycle after release presents address 0.
- R6: `halt_n` is sampled at the edge that ends the fourth quarter. When it is low, the following cycles hold `addr`, and a jump strobe given during a halted cycle is ignored.
- R7: In a running cycle `lb_n`/`rb_n` follow `lb_req_n`/`rb_req_n`. In every halted cycle both are 1 from the first quarter on, whatever the requests are.
- R8: Halt ends at a cycle boundary when `halt_n` is high at the end of a halted cycle. The next running cycle presents the held address, and the cycle after it presents the held address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate clock; both oscillator edges folded into one edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_n | input | 1 | Active-low halt, sampled at the end of a cycle |
| jmp_ld | input | 1 | Jump strobe from decode |
| jmp_tgt | input | AW (13) | Jump target address |
| lb_req_n | input | 1 | Left bank request from decode, active low |
| rb_req_n | input | 1 | Right bank request from decode, active low |
| addr | output | AW (13) | Program address bus |
| mclk | output | 1 | Master clock for peripherals |
| phase | output | 4 | One-hot quarter indicator |
| lb_n | output | 1 | Left bank select, active low |
| rb_n | output | 1 | Right bank select, active low |

## Verification
The bench builds the sequencer with its default 13-bit address width. This lets a jump to 8191 followed by a plain cycle show the wrap to address 0. With that width the jump target is also as wide as the whole program space, so loads into the top of the address range can be exercised directly. The bench places jump strobes in the second quarter and also only in the first or only in the fourth quarter. It starts halts both in a cycle that also jumps and in a plain cycle, and it pulls reset low in the middle of a cycle.

// File: rtl/instr_cycle_seq_pkg.sv
package instr_cycle_seq_pkg;
    localparam int QUARTERS = 4;
    localparam int QW       = $clog2(QUARTERS);

    typedef enum logic [2:0] {
        ST_Q1   = 3'd0,
        ST_Q2   = 3'd1,
        ST_Q3   = 3'd2,
        ST_Q4   = 3'd3,
        ST_HALT = 3'd4
    } seq_state_e;
endpackage

// File: rtl/icseq_phase_gen.sv
module icseq_phase_gen
    import instr_cycle_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [QUARTERS-1:0] phase,
    output logic                q_last,
    output logic                mclk
);
    logic [QW-1:0] qcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt   <= '0;
            mclk   <= 1'b0;
        end else begin
            qcnt   <= qcnt + QW'(1);
            // high for the whole quarter that follows the third
            mclk   <= (qcnt == QW'(QUARTERS - 2));
        end
    end

    assign q_last = (qcnt == QW'(QUARTERS - 1));

    generate
        for (genvar i = 0; i < QUARTERS; i++) begin : g_phase
            assign phase[i] = (qcnt == QW'(i));
        end
    endgenerate
endmodule

// File: rtl/icseq_fsm.sv
module icseq_fsm
    import instr_cycle_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_n,
    input  logic q_last,
    output logic cap_en,
    output logic upd_en,
    output logic commit_en,
    output logic halt_next
);
    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_Q1:   state_nx = ST_Q2;
            ST_Q2:   state_nx = ST_Q3;
            ST_Q3:   state_nx = ST_Q4;
            ST_Q4:   state_nx = halt_n ? ST_Q1 : ST_HALT;
            ST_HALT: state_nx = (q_last && halt_n) ? ST_Q1 : ST_HALT;
            default: state_nx = ST_Q1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_Q1;
        else        state <= state_nx;
    end

    always_comb begin
        cap_en    = 1'b0;
        upd_en    = 1'b0;
        commit_en = 1'b0;
        unique case (state)
            ST_Q1:   ;
            ST_Q2:   cap_en    = 1'b1;
            ST_Q3:   upd_en    = 1'b1;
            ST_Q4:   commit_en = 1'b1;
            ST_HALT: ;
            default: ;
        endcase
        halt_next = (state_nx == ST_HALT);
    end
endmodule

// File: rtl/icseq_addr_path.sv
module icseq_addr_path #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          upd_en,
    input  logic          commit_en,
    input  logic          jmp_ld,
    input  logic [AW-1:0] jmp_tgt,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] pc, ar, tgt_q, inc;
    logic          ld_q;

    assign inc = pc + AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            ar    <= '0;
            tgt_q <= '0;
            ld_q  <= 1'b0;
        end else begin
            if (cap_en) begin
                ld_q  <= jmp_ld;
                tgt_q <= jmp_tgt;
            end
            if (upd_en)    ar <= ld_q ? tgt_q : inc;
            if (commit_en) pc <= ar;
        end
    end

    assign addr = ar;
endmodule

// File: rtl/icseq_bank_ctl.sv
module icseq_bank_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_next,
    input  logic lb_req_n,
    input  logic rb_req_n,
    output logic lb_n,
    output logic rb_n
);
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= halt_next;
    end

    assign lb_n = lb_req_n | hold_q | ~rst_n;
    assign rb_n = rb_req_n | hold_q | ~rst_n;
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import instr_cycle_seq_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_n,
    input  logic          jmp_ld,
    input  logic [AW-1:0] jmp_tgt,
    input  logic          lb_req_n,
    input  logic          rb_req_n,
    output logic [AW-1:0] addr,
    output logic          mclk,
    output logic [3:0]    phase,
    output logic          lb_n,
    output logic          rb_n
);
    logic q_last, cap_en, upd_en, commit_en, halt_next;

    icseq_phase_gen u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .q_last (q_last),
        .mclk   (mclk)
    );

    icseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_n    (halt_n),
        .q_last    (q_last),
        .cap_en    (cap_en),
        .upd_en    (upd_en),
        .commit_en (commit_en),
        .halt_next (halt_next)
    );

    icseq_addr_path #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .upd_en    (upd_en),
        .commit_en (commit_en),
        .jmp_ld    (jmp_ld),
        .jmp_tgt   (jmp_tgt),
        .addr      (addr)
    );

    icseq_bank_ctl u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_next (halt_next),
        .lb_req_n  (lb_req_n),
        .rb_req_n  (rb_req_n),
        .lb_n      (lb_n),
        .rb_n      (rb_n)
    );
endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt_n,
    input logic [AW-1:0] addr,
    input logic          mclk,
    input logic [3:0]    phase,
    input logic          lb_n,
    input logic          rb_n
);
    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> phase[0]);

    // R2
    mclk_last_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk == phase[3]);

    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[2] |=> $stable(addr));

    // R6
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !halt_n) |=> $stable(addr));

    // R7
    halt_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !halt_n) |=> (lb_n && rb_n));

    // R5
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_force_chk: assert (lb_n && rb_n && !mclk && addr == '0);
        end
    end
endmodule

bind instr_cycle_seq instr_cycle_seq_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt_n (halt_n),
    .addr   (addr),
    .mclk   (mclk),
    .phase  (phase),
    .lb_n   (lb_n),
    .rb_n   (rb_n)
);

// File: tb/instr_cycle_seq_tb.sv
module instr_cycle_seq_tb;
    localparam int CLK_T = 10;
    localparam int AW    = 13;

    typedef struct {
        logic [AW-1:0] a;
        logic          lb;
        logic          rb;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_n = 1'b1;
    logic          jmp_ld = 1'b0;
    logic [AW-1:0] jmp_tgt = '0;
    logic          lb_req_n = 1'b1;
    logic          rb_req_n = 1'b1;
    logic [AW-1:0] addr;
    logic          mclk;
    logic [3:0]    phase;
    logic          lb_n, rb_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    exp_t          sb[$];
    logic [AW-1:0] exp_addr = '0;
    bit            cur_halted = 0;

    always #(CLK_T/2) clk = ~clk;

    instr_cycle_seq #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .jmp_ld(jmp_ld),
        .jmp_tgt(jmp_tgt), .lb_req_n(lb_req_n), .rb_req_n(rb_req_n),
        .addr(addr), .mclk(mclk), .phase(phase), .lb_n(lb_n), .rb_n(rb_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one instruction cycle; win 0 = strobe whole cycle, 1 = first quarter only, 2 = fourth quarter only
    task automatic do_cycle(input logic ld, input logic [AW-1:0] tgt, input int win,
                            input logic hn, input logic lbr, input logic rbr, input string tag);
        exp_t e;
        do @(negedge clk); while (!phase[0]);
        e.a   = exp_addr;
        e.lb  = cur_halted ? 1'b1 : lbr;
        e.rb  = cur_halted ? 1'b1 : rbr;
        e.tag = tag;
        sb.push_back(e);
        halt_n = hn; lb_req_n = lbr; rb_req_n = rbr; jmp_tgt = tgt;
        jmp_ld = (win == 2) ? 1'b0 : ld;
        @(negedge clk);
        if (win == 1) jmp_ld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (win == 2) jmp_ld = ld;
        if (!cur_halted) exp_addr = (ld && win == 0) ? tgt : exp_addr + AW'(1);
        cur_halted = !hn;
    endtask

    // monitor: quarter and clock shape every quarter, scoreboard item in each second quarter
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 phase onehot", 32'($countones(phase)), 32'd1);
            chk("R2 mclk in fourth quarter", {31'b0, mclk}, {31'b0, phase[3]});
            if (phase[1] && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " addr"}, 32'(addr), 32'(e.a));
                chk({e.tag, " R7 lb_n"}, {31'b0, lb_n}, {31'b0, e.lb});
                chk({e.tag, " R7 rb_n"}, {31'b0, rb_n}, {31'b0, e.rb});
            end
        end
    end

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        lb_req_n = 1'b0; rb_req_n = 1'b0;
        #(CLK_T + 2);
        // R5 reset state
        chk("R5 reset addr", 32'(addr), 32'd0);
        chk("R5 reset mclk", {31'b0, mclk}, 32'd0);
        chk("R5 reset lb_n", {31'b0, lb_n}, 32'd1);
        chk("R5 reset rb_n", {31'b0, rb_n}, 32'd1);
        @(posedge clk); #2 rst_n = 1'b1;

        // R5 first cycle at 0, R3 sequential, R7 bank follow
        do_cycle(0, '0, 0, 1, 0, 1, "R5 first");
        do_cycle(0, '0, 0, 1, 1, 0, "R3 seq");
        do_cycle(0, '0, 0, 1, 0, 0, "R3 seq");
        do_cycle(0, '0, 0, 1, 1, 1, "R3 seq");
        // R4 jump in second quarter
        do_cycle(1, 13'd100, 0, 1, 1, 1, "R4 jump");
        do_cycle(0, '0, 0, 1, 1, 1, "R4 target");
        // R4 strobe only in first / fourth quarter ignored
        do_cycle(1, 13'd555, 1, 1, 1, 1, "R4 q1 strobe");
        do_cycle(1, 13'd777, 2, 1, 1, 1, "R4 q4 strobe");
        do_cycle(0, '0, 0, 1, 1, 1, "R4 no jump");
        // R3 wrap
        do_cycle(1, 13'h1FFF, 0, 1, 1, 1, "R3 wrap jump");
        do_cycle(0, '0, 0, 1, 1, 1, "R3 top");
        do_cycle(0, '0, 0, 1, 1, 1, "R3 wrapped");
        // R6 halt taken in a jumping cycle
        do_cycle(1, 13'd40, 0, 0, 0, 0, "R6 halt req");
        do_cycle(1, 13'd900, 0, 0, 0, 0, "R6 halted jump");
        do_cycle(0, '0, 0, 0, 0, 1, "R6 halted");
        do_cycle(0, '0, 0, 1, 0, 0, "R8 release");
        do_cycle(0, '0, 0, 1, 0, 0, "R8 resumed");
        do_cycle(0, '0, 0, 1, 1, 0, "R8 next");
        // R6 halt from a plain cycle, R2 mclk continues
        do_cycle(0, '0, 0, 0, 0, 0, "R6 halt req2");
        do_cycle(0, '0, 0, 1, 0, 0, "R6 halted2");
        do_cycle(0, '0, 0, 1, 0, 1, "R8 resumed2");
        do_cycle(0, '0, 0, 1, 0, 1, "R8 next2");
        chk("R3 scoreboard drained", 32'(sb.size()), 32'd0);

        // R5 asynchronous reset mid cycle
        #2 rst_n = 1'b0;
        #1;
        chk("R5 async addr", 32'(addr), 32'd0);
        chk("R5 async mclk", {31'b0, mclk}, 32'd0);
        chk("R5 async lb_n", {31'b0, lb_n}, 32'd1);
        chk("R5 async rb_n", {31'b0, rb_n}, 32'd1);
        sb.delete();
        exp_addr = '0; cur_halted = 0; jmp_ld = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
        do_cycle(0, '0, 0, 1, 0, 1, "R5 restart");
        do_cycle(0, '0, 0, 1, 1, 0, "R5 restart next");
        @(negedge clk);
        @(negedge clk);
        chk("R3 scoreboard drained", 32'(sb.size()), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule